// File: doc/BRIEF.md
# Serial EPROM Read Command Engine

This block is the slave-side sequencer of a 128-byte serial EPROM that is read over an abstracted single-wire link. The analog wire timing is handled elsewhere and arrives here as one-cycle strobes: a reset strobe, a write-slot strobe with its data bit, and a read-slot strobe that the engine answers with a registered return bit. After a reset strobe the engine collects a skip-ROM byte, then a command byte and a two-byte start address. It then answers read slots with a checksum of what it received, followed by the array contents.

Two read commands are supported, and both use one bit-serial CRC-8 generator. In page mode a CRC byte follows the last byte of every 32-byte page, so each page reads as 33 bytes. In field mode a single CRC follows the last byte of the array. In both modes, once the final CRC has been sent every further read slot returns 1 until the next reset strobe. The array itself is a register file with a plain write port that the surrounding system (here, the testbench) uses to load it.

Top module: `eprom_read_engine`

## Requirements
- R1: After a reset strobe, the first 8 write slots form a byte, LSB first. Only CCh (skip) lets the sequence go on. Any other value halts the engine, and all later slots are ignored (reads return 1) until the next reset strobe. Before the first reset strobe the engine is halted in the same way.
- R2: The command byte C3h selects page mode and F0h selects field mode. Any other command byte halts the engine until a reset strobe.
- R3: After the command, the engine takes the start address as a low byte and then a high byte, each LSB first, forming a 16-bit address.
- R4: The 8 read slots after the address return, LSB first, a CRC-8 over the command byte and both address bytes. The CRC uses x^8+x^5+x^4+1 in reflected form (mask 8Ch), starts at zero and takes data one bit at a time, LSB first.
- R5: Data bytes are returned LSB first, starting at the start address and counting up one byte at a time.
- R6: In page mode, after a byte whose index has its five low bits all 1, the next 8 read slots return the CRC over the data bytes sent since the start or since the previous page CRC. Data then resumes at the first byte of the next page.
- R7: In field mode there is no CRC between pages. After byte 127, the next 8 read slots return the CRC over every data byte from the start byte through byte 127.
- R8: After the final CRC, in either mode, every read slot returns 1 until a reset strobe.
- R9: A reset strobe at any point abandons the current read, returns no CRC for it, sets the return bit to 1 on the next clock, and restarts the sequence at the skip byte.
- R10: A start address of 128 or more skips the data: the next 8 read slots return the CRC 00h, and then only 1s follow.
- R11: The return bit changes only on the clock edge after a read slot or a reset strobe, and holds between them. After the system reset it is 1.
- R12: A read slot while the engine expects write slots returns 1 and changes no state. A write slot while the engine is sending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| slot_reset | input | 1 | One-cycle strobe: reset pulse seen on the wire |
| wr_slot | input | 1 | One-cycle strobe: host write slot |
| wr_bit | input | 1 | Data bit of the write slot |
| rd_slot | input | 1 | One-cycle strobe: host read slot |
| rd_bit | output | 1 | Registered bit returned for the last read slot |
| load_en | input | 1 | Write enable of the array load port |
| load_addr | input | 7 | Array byte index to load |
| load_data | input | 8 | Byte to load |

## Verification
Every result the engine returns is due on the clock edge right after its strobe: a read slot registers its bit there, and a reset strobe forces the return bit to 1 there. The bench raises each strobe on a falling edge for exactly one cycle and samples the return bit at the next falling edge, half a cycle after the edge that registered it. A reference model in the bench computes the expected CRC and page sequencing from the requirements. The bench compares whole returned bytes, including every CRC, and it checks that the return bit holds over several idle cycles.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

   localparam int ADDR_W = 16;

   typedef enum logic [3:0] {
      PH_HALT,
      PH_ROM,
      PH_CMD,
      PH_ADRL,
      PH_ADRH,
      PH_HDR_CRC,
      PH_DATA,
      PH_BLK_CRC,
      PH_ONES
   } phase_t;

   typedef enum logic {
      MODE_PAGE,
      MODE_FIELD
   } mode_t;

endpackage

// File: rtl/eprom_crc8.sv
module eprom_crc8 #(
   parameter logic [7:0] POLY_REV = 8'h8C
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       step,
   input  logic       din,
   output logic [7:0] crc_q
);

   generate
      if (POLY_REV[7] != 1'b1) begin : g_bad_poly
         $error("eprom_crc8: reflected polynomial must have its top bit set");
      end
   endgenerate

   logic       fb;
   logic [7:0] nxt;

   assign fb = crc_q[0] ^ din;

   genvar g;
   generate
      for (g = 0; g < 8; g++) begin : g_bit
         if (g == 7) begin : g_top
            assign nxt[g] = POLY_REV[g] & fb;
         end else begin : g_low
            assign nxt[g] = crc_q[g+1] ^ (POLY_REV[g] & fb);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= 8'h00;
      end else if (clr) begin
         crc_q <= 8'h00;
      end else if (step) begin
         crc_q <= nxt;
      end
   end

   AST_CRC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step) |=> $stable(crc_q)) else $error("crc changed without step"); // R4

endmodule

// File: rtl/eprom_mem.sv
module eprom_mem #(
   parameter int BYTES = 128,
   localparam int IDX_W = $clog2(BYTES)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [7:0]       wdata,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [2:0]       rd_sel,
   output logic             rd_out
);

   generate
      if ((1 << IDX_W) != BYTES) begin : g_bad_depth
         $error("eprom_mem: depth must be a power of two");
      end
   endgenerate

   logic [7:0] arr [BYTES];

   genvar g;
   generate
      for (g = 0; g < BYTES; g++) begin : g_row
         always_ff @(posedge clk) begin
            if (we && (waddr == IDX_W'(g))) begin
               arr[g] <= wdata;
            end
         end
      end
   endgenerate

   logic [7:0] sel_byte;
   assign sel_byte = arr[rd_idx];
   assign rd_out   = sel_byte[rd_sel];

endmodule

// File: rtl/eprom_seq.sv
module eprom_seq
   import eprom_pkg::*;
#(
   parameter int         MEM_BYTES  = 128,
   parameter int         PAGE_BYTES = 32,
   parameter logic [7:0] CODE_SKIP  = 8'hCC,
   parameter logic [7:0] CODE_PAGE  = 8'hC3,
   parameter logic [7:0] CODE_FIELD = 8'hF0,
   localparam int IDX_W = $clog2(MEM_BYTES),
   localparam int PG_W  = $clog2(PAGE_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_reset,
   input  logic             wr_slot,
   input  logic             wr_bit,
   input  logic             rd_slot,
   output logic             rd_bit,
   output logic [IDX_W-1:0] mem_idx,
   output logic [2:0]       mem_sel,
   input  logic             mem_bit,
   output logic             crc_clr,
   output logic             crc_step,
   output logic             crc_din,
   input  logic [7:0]       crc_q
);

   generate
      if (PAGE_BYTES > MEM_BYTES || (1 << PG_W) != PAGE_BYTES) begin : g_bad_page
         $error("eprom_seq: page must be a power of two no larger than the array");
      end
      if (IDX_W > ADDR_W) begin : g_bad_addr
         $error("eprom_seq: array exceeds the address range");
      end
   endgenerate

   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(MEM_BYTES - 1);
   localparam logic [ADDR_W-1:0] END_ADR  = ADDR_W'(MEM_BYTES);

   phase_t            phase;
   mode_t             mode;
   logic [2:0]        bit_cnt;
   logic [6:0]        rx_sr;
   logic [7:0]        adr_lo;
   logic [ADDR_W-1:0] adr_q;
   logic [IDX_W-1:0]  byte_idx;
   logic              last_blk;
   logic              rd_q;

   logic       in_rx, in_tx, wr_take, rd_take, byte_end, out_bit, page_end;
   logic [7:0] rx_full;

   assign in_rx    = (phase == PH_ROM) || (phase == PH_CMD) ||
                     (phase == PH_ADRL) || (phase == PH_ADRH);
   assign in_tx    = (phase == PH_HDR_CRC) || (phase == PH_DATA) ||
                     (phase == PH_BLK_CRC);
   assign wr_take  = !slot_reset && wr_slot && in_rx;
   assign rd_take  = !slot_reset && !wr_slot && rd_slot && in_tx;
   assign byte_end = (bit_cnt == 3'd7);
   assign rx_full  = {wr_bit, rx_sr};
   assign out_bit  = (phase == PH_DATA) ? mem_bit : crc_q[bit_cnt];
   assign page_end = &byte_idx[PG_W-1:0];

   assign mem_idx  = byte_idx;
   assign mem_sel  = bit_cnt;
   assign crc_din  = (phase == PH_DATA) ? mem_bit : wr_bit;
   assign crc_step = (wr_take && phase != PH_ROM) || (rd_take && phase == PH_DATA);
   assign crc_clr  = slot_reset ||
                     (rd_take && byte_end && (phase == PH_HDR_CRC || phase == PH_BLK_CRC));
   assign rd_bit   = rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_HALT;
         mode     <= MODE_FIELD;
         bit_cnt  <= 3'd0;
         rx_sr    <= 7'd0;
         adr_lo   <= 8'd0;
         adr_q    <= '0;
         byte_idx <= '0;
         last_blk <= 1'b0;
         rd_q     <= 1'b1;
      end else if (slot_reset) begin
         phase    <= PH_ROM;
         bit_cnt  <= 3'd0;
         last_blk <= 1'b0;
         rd_q     <= 1'b1;
      end else if (wr_take) begin
         rx_sr   <= rx_full[7:1];
         bit_cnt <= bit_cnt + 3'd1;
         if (byte_end) begin
            unique case (phase)
               PH_ROM:  phase <= (rx_full == CODE_SKIP) ? PH_CMD : PH_HALT;
               PH_CMD: begin
                  if (rx_full == CODE_PAGE) begin
                     mode  <= MODE_PAGE;
                     phase <= PH_ADRL;
                  end else if (rx_full == CODE_FIELD) begin
                     mode  <= MODE_FIELD;
                     phase <= PH_ADRL;
                  end else begin
                     phase <= PH_HALT;
                  end
               end
               PH_ADRL: begin
                  adr_lo <= rx_full;
                  phase  <= PH_ADRH;
               end
               default: begin
                  adr_q <= {rx_full, adr_lo};
                  phase <= PH_HDR_CRC;
               end
            endcase
         end
      end else if (rd_slot) begin
         rd_q <= rd_take ? out_bit : 1'b1;
         if (rd_take) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (byte_end) begin
               unique case (phase)
                  PH_HDR_CRC: begin
                     if (adr_q >= END_ADR) begin
                        last_blk <= 1'b1;
                        phase    <= PH_BLK_CRC;
                     end else begin
                        byte_idx <= adr_q[IDX_W-1:0];
                        phase    <= PH_DATA;
                     end
                  end
                  PH_DATA: begin
                     if (byte_idx == LAST_IDX) begin
                        last_blk <= 1'b1;
                        phase    <= PH_BLK_CRC;
                     end else begin
                        byte_idx <= byte_idx + IDX_W'(1);
                        if (mode == MODE_PAGE && page_end) begin
                           phase <= PH_BLK_CRC;
                        end
                     end
                  end
                  default: phase <= last_blk ? PH_ONES : PH_DATA;
               endcase
            end
         end
      end
   end

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_slot && !slot_reset) |=> $stable(rd_q)) else $error("return bit moved"); // R11
   AST_RST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      slot_reset |=> (rd_q && phase == PH_ROM)) else $error("reset strobe ignored"); // R9
   AST_ONES_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_ONES || phase == PH_HALT) && rd_slot) |=> rd_q) else $error("idle read not 1"); // R8
   AST_WR_IGNORED_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_slot && !slot_reset && in_tx) |=> ($stable(bit_cnt) && $stable(byte_idx) && $stable(phase)))
      else $error("write slot disturbed sending"); // R12
   AST_PAGE_CRC_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_PAGE && phase == PH_DATA && rd_slot && !wr_slot && !slot_reset &&
       byte_end && page_end) |=> (phase == PH_BLK_CRC)) else $error("page crc missing"); // R6
   AST_FIELD_NO_MID_CRC: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_FIELD && phase == PH_DATA && rd_slot && !wr_slot && !slot_reset &&
       byte_idx != LAST_IDX) |=> (phase == PH_DATA)) else $error("field crc inserted early"); // R7
   AST_BAD_CMD_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CMD && wr_slot && !slot_reset && byte_end &&
       rx_full != CODE_PAGE && rx_full != CODE_FIELD) |=> (phase == PH_HALT))
      else $error("unknown command accepted"); // R2

endmodule

// File: rtl/eprom_read_engine.sv
module eprom_read_engine #(
   parameter int         MEM_BYTES  = 128,
   parameter int         PAGE_BYTES = 32,
   parameter logic [7:0] CODE_SKIP  = 8'hCC,
   parameter logic [7:0] CODE_PAGE  = 8'hC3,
   parameter logic [7:0] CODE_FIELD = 8'hF0,
   parameter logic [7:0] POLY_REV   = 8'h8C,
   localparam int IDX_W = $clog2(MEM_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_reset,
   input  logic             wr_slot,
   input  logic             wr_bit,
   input  logic             rd_slot,
   output logic             rd_bit,
   input  logic             load_en,
   input  logic [IDX_W-1:0] load_addr,
   input  logic [7:0]       load_data
);

   logic [IDX_W-1:0] mem_idx;
   logic [2:0]       mem_sel;
   logic             mem_bit;
   logic             crc_clr, crc_step, crc_din;
   logic [7:0]       crc_q;

   eprom_mem #(.BYTES(MEM_BYTES)) mem_i (
      .clk    (clk),
      .we     (load_en),
      .waddr  (load_addr),
      .wdata  (load_data),
      .rd_idx (mem_idx),
      .rd_sel (mem_sel),
      .rd_out (mem_bit)
   );

   eprom_crc8 #(.POLY_REV(POLY_REV)) crc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .step  (crc_step),
      .din   (crc_din),
      .crc_q (crc_q)
   );

   eprom_seq #(
      .MEM_BYTES  (MEM_BYTES),
      .PAGE_BYTES (PAGE_BYTES),
      .CODE_SKIP  (CODE_SKIP),
      .CODE_PAGE  (CODE_PAGE),
      .CODE_FIELD (CODE_FIELD)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_reset (slot_reset),
      .wr_slot    (wr_slot),
      .wr_bit     (wr_bit),
      .rd_slot    (rd_slot),
      .rd_bit     (rd_bit),
      .mem_idx    (mem_idx),
      .mem_sel    (mem_sel),
      .mem_bit    (mem_bit),
      .crc_clr    (crc_clr),
      .crc_step   (crc_step),
      .crc_din    (crc_din),
      .crc_q      (crc_q)
   );

endmodule

// File: tb/eprom_read_engine_tb_top.sv
`timescale 1ns/1ps
module eprom_read_engine_tb_top;

   typedef struct packed {
      logic [7:0]  cmd;
      logic [15:0] adr;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{8'hC3, 16'h0000}, '{8'hC3, 16'h0011}, '{8'hC3, 16'h0060}, '{8'hF0, 16'h0000},
      '{8'hF0, 16'h0075}, '{8'hC3, 16'h007F}, '{8'hF0, 16'h0080}, '{8'hC3, 16'h0100}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slot_reset = 1'b0, wr_slot = 1'b0, wr_bit = 1'b0, rd_slot = 1'b0;
   logic       rd_bit;
   logic       load_en = 1'b0;
   logic [6:0] load_addr = '0;
   logic [7:0] load_data = '0;
   int         n_checks = 0, n_errors = 0;
   bit         done = 1'b0;
   logic [7:0] ref_mem [128];

   always #10 clk = ~clk;

   eprom_read_engine dut_i (
      .clk(clk), .rst_n(rst_n), .slot_reset(slot_reset), .wr_slot(wr_slot),
      .wr_bit(wr_bit), .rd_slot(rd_slot), .rd_bit(rd_bit),
      .load_en(load_en), .load_addr(load_addr), .load_data(load_data)
   );

   function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] d);
      for (int i = 0; i < 8; i++) begin
         logic fb;
         fb = c[0] ^ d[i];
         c  = c >> 1;
         if (fb) c = c ^ 8'h8C;
      end
      return c;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse_reset();
      @(negedge clk) slot_reset = 1'b1;
      @(negedge clk) slot_reset = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk) begin wr_slot = 1'b1; wr_bit = b; end
      @(negedge clk) wr_slot = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_bit(v[i]);
   endtask

   task automatic read_bit(output logic b);
      @(negedge clk) rd_slot = 1'b1;
      @(negedge clk) rd_slot = 1'b0;
      b = rd_bit;
   endtask

   task automatic read_byte(output logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         logic b;
         read_bit(b);
         v[i] = b;
      end
   endtask

   task automatic open_read(input logic [7:0] cmd, input logic [15:0] adr);
      logic [7:0] got;
      pulse_reset();
      send_byte(8'hCC);
      send_byte(cmd);
      send_byte(adr[7:0]);
      send_byte(adr[15:8]);
      read_byte(got);
      check("R4 header crc", got, crc_add(crc_add(crc_add(8'h00, cmd), adr[7:0]), adr[15:8]));
   endtask

   // Reference stream: data, page or field CRC, then ones (R5 R6 R7 R8 R10)
   task automatic stream_rest(input logic page, input logic [15:0] adr);
      logic [7:0] got, c;
      c = 8'h00;
      if (adr >= 16'd128) begin
         read_byte(got);
         check("R10 crc of empty read", got, 8'h00);
      end else begin
         for (int idx = int'(adr); idx < 128; idx++) begin
            read_byte(got);
            check("R5 data byte", got, ref_mem[idx]);
            c = crc_add(c, ref_mem[idx]);
            if (idx == 127 || (page && (idx % 32) == 31)) begin
               read_byte(got);
               check(page ? "R6 page crc" : "R7 field crc", got, c);
               c = 8'h00;
            end
         end
      end
      for (int k = 0; k < 2; k++) begin
         read_byte(got);
         check("R8 ones after final crc", got, 8'hFF);
      end
   endtask

   initial begin
      logic [7:0] got;
      logic       b, held;
      for (int i = 0; i < 128; i++) ref_mem[i] = 8'(i * 29 + 7) ^ 8'(i >> 3);
      repeat (3) @(negedge clk);
      check("R11 return bit after system reset", {7'd0, rd_bit}, 8'd1);
      rst_n = 1'b1;
      for (int i = 0; i < 128; i++) begin
         @(negedge clk) begin load_en = 1'b1; load_addr = 7'(i); load_data = ref_mem[i]; end
      end
      @(negedge clk) load_en = 1'b0;

      // R1: halted before any reset strobe
      send_byte(8'hCC); send_byte(8'hF0); send_byte(8'h00); send_byte(8'h00);
      read_byte(got);
      check("R1 halted before reset strobe", got, 8'hFF);

      // R1: wrong skip byte
      pulse_reset();
      send_byte(8'h33); send_byte(8'hC3); send_byte(8'h00); send_byte(8'h00);
      read_byte(got);
      check("R1 wrong skip byte ignored", got, 8'hFF);

      // R2: unknown command
      pulse_reset();
      send_byte(8'hCC); send_byte(8'h55); send_byte(8'h00); send_byte(8'h00);
      read_byte(got);
      check("R2 unknown command halts", got, 8'hFF);

      // R12 and R3: read slot in address phase, write slot while sending
      pulse_reset();
      send_byte(8'hCC); send_byte(8'hF0); send_byte(8'h10);
      read_bit(b);
      check("R12 read slot during address phase", {7'd0, b}, 8'd1);
      send_byte(8'h00);
      read_byte(got);
      check("R3 header crc after stray read", got, crc_add(crc_add(crc_add(8'h00, 8'hF0), 8'h10), 8'h00));
      read_byte(got); check("R3 first byte at start address", got, ref_mem[16]);
      read_byte(got); check("R5 second byte", got, ref_mem[17]);
      held = rd_bit;
      repeat (5) @(negedge clk);
      check("R11 return bit holds while idle", {7'd0, rd_bit}, {7'd0, held});
      send_bit(1'b0);
      read_byte(got); check("R12 write slot while sending ignored", got, ref_mem[18]);

      // R9: reset strobe mid-stream
      open_read(8'hC3, 16'h0005);
      for (int i = 0; i < 3; i++) begin
         read_byte(got);
         check("R5 page data", got, ref_mem[5 + i]);
      end
      pulse_reset();
      check("R9 return bit 1 after reset strobe", {7'd0, rd_bit}, 8'd1);
      read_bit(b);
      check("R9 read after abandon returns 1", {7'd0, b}, 8'd1);
      pulse_reset();
      send_byte(8'hCC); send_byte(8'hF0); send_byte(8'h7E); send_byte(8'h00);
      read_byte(got);
      check("R9 fresh header crc", got, crc_add(crc_add(crc_add(8'h00, 8'hF0), 8'h7E), 8'h00));
      stream_rest(1'b0, 16'h007E);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         open_read(VECS[v].cmd, VECS[v].adr);
         stream_rest(VECS[v].cmd == 8'hC3, VECS[v].adr);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule